// File: doc/BRIEF.md
# Two-Player Win Scorekeeper

This block keeps the score for a two-player button race. The game logic raises a one-cycle win pulse for the left or the right player. The block then adds one point to that player's 3-bit score and shows each score on its own seven-segment digit. One cycle later it sends a one-cycle restart pulse back to the game, so the game clears its playfield and a new round begins. Scores survive a restart.

A synchronous reset clears both scores. The restart output stays high for as long as reset is asserted, so a full reset also clears the playfield. A score stops at 7. When both players win in the same cycle, the left player gets the point.

Top module: `duel_scoreboard`

## Requirements
- R1: While `rst` is high at a rising edge, both scores become 0, and both digits show the pattern for 0 on the next cycle.
- R2: `restart` is high in every cycle in which `rst` is high.
- R3: A left win pulse with the left score below 7 adds one to the left score. The right score does not change.
- R4: A right win pulse with the left input low and the right score below 7 adds one to the right score. The left score does not change.
- R5: When both win inputs are high in the same cycle, only the left score increments.
- R6: A score of 7 stays at 7 on any further win. It does not wrap to 0.
- R7: `restart` is high for exactly the one cycle that follows a cycle with a win input seen out of reset. It is low otherwise, and the scores are kept across it.
- R8: Win inputs have no effect on either score while `rst` is high.
- R9: The segment outputs are active-low, with segment a on bit 0 through segment g on bit 6. Digits 0 to 7 show 7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02 and 7'h78.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the scores and forces a restart |
| win_l | input | 1 | One-cycle win pulse for the left player |
| win_r | input | 1 | One-cycle win pulse for the right player |
| restart | output | 1 | Playfield restart pulse |
| seg_l | output | 7 | Active-low seven-segment digit for the left score |
| seg_r | output | 7 | Active-low seven-segment digit for the right score |

## Verification
The hardest situation to reach is a saturated score that then receives more wins, with the other player's score at a different value. The stimulus first runs a series of back-to-back left wins past 7. It then runs a longer series of right wins with a few simultaneous wins mixed in. At that point a wrap or a wrong priority shows up on the other player's digit. Reset is also asserted while win pulses are active, both at the start of the run and in the middle of it.

// File: rtl/duel_scoreboard.sv
module duel_scoreboard (
  input  logic       clk,
  input  logic       rst,
  input  logic       win_l,
  input  logic       win_r,
  output logic       restart,
  output logic [6:0] seg_l,
  output logic [6:0] seg_r
);
  localparam int SCORE_W = 3;
  localparam logic [SCORE_W-1:0] TOP = '1;

  logic [SCORE_W-1:0] score_l, score_r;
  logic               won_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      score_l <= '0;
      score_r <= '0;
      won_q   <= 1'b0;
    end else begin
      won_q <= win_l | win_r;
      if (win_l) begin
        if (score_l != TOP) score_l <= score_l + 1'b1;
      end else if (win_r) begin
        if (score_r != TOP) score_r <= score_r + 1'b1;
      end
    end
  end

  function automatic logic [6:0] to_seg(input logic [SCORE_W-1:0] v);
    logic [6:0] on;
    case (v)
      3'd0:    on = 7'b0111111;
      3'd1:    on = 7'b0000110;
      3'd2:    on = 7'b1011011;
      3'd3:    on = 7'b1001111;
      3'd4:    on = 7'b1100110;
      3'd5:    on = 7'b1101101;
      3'd6:    on = 7'b1111101;
      default: on = 7'b0000111;
    endcase
    return ~on;
  endfunction

  assign restart = won_q | rst;
  assign seg_l   = to_seg(score_l);
  assign seg_r   = to_seg(score_r);
endmodule

// File: rtl/duel_scoreboard_chk.sv
module duel_scoreboard_chk (
  input logic       clk,
  input logic       rst,
  input logic       win_l,
  input logic       win_r,
  input logic       restart,
  input logic [6:0] seg_l,
  input logic [6:0] seg_r
);
  localparam logic [6:0] DIG0 = 7'h40;
  localparam logic [6:0] DIG7 = 7'h78;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (seg_l == DIG0 && seg_r == DIG0)); // R1
  AST_RESTART_IN_RESET: assert property (@(posedge clk) rst |-> restart); // R2
  AST_LEFT_KEEPS_RIGHT: assert property (@(posedge clk) disable iff (rst) win_l |=> $stable(seg_r)); // R5
  AST_IDLE_KEEPS_LEFT: assert property (@(posedge clk) disable iff (rst) !win_l |=> $stable(seg_l)); // R4
  AST_SAT_LEFT: assert property (@(posedge clk) disable iff (rst) (seg_l == DIG7) |=> (seg_l == DIG7)); // R6
  AST_SAT_RIGHT: assert property (@(posedge clk) disable iff (rst) (seg_r == DIG7) |=> (seg_r == DIG7)); // R6
  AST_RESTART_AFTER_WIN: assert property (@(posedge clk) disable iff (rst) (win_l || win_r) |=> restart); // R7
  AST_NO_SPURIOUS_RESTART: assert property (@(posedge clk) disable iff (rst) !(win_l || win_r) |=> !restart); // R7
endmodule

bind duel_scoreboard duel_scoreboard_chk u_chk (
  .clk(clk), .rst(rst), .win_l(win_l), .win_r(win_r),
  .restart(restart), .seg_l(seg_l), .seg_r(seg_r)
);

// File: tb/sim_duel_scoreboard.sv
module sim_duel_scoreboard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic win_l = 1'b0;
  logic win_r = 1'b0;
  logic restart;
  logic [6:0] seg_l, seg_r;

  always #5 clk = ~clk;

  duel_scoreboard u0 (
    .clk(clk), .rst(rst), .win_l(win_l), .win_r(win_r),
    .restart(restart), .seg_l(seg_l), .seg_r(seg_r)
  );

  typedef struct {
    logic [6:0] el;
    logic [6:0] er;
    logic       rs;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int ml = 0, mr = 0;
  logic mwon = 1'b0;
  bit done = 1'b0;

  // R9: active-low digit patterns, segment a on bit 0
  function automatic logic [6:0] digit(input int v);
    case (v)
      0: return 7'h40;
      1: return 7'h79;
      2: return 7'h24;
      3: return 7'h30;
      4: return 7'h19;
      5: return 7'h12;
      6: return 7'h02;
      default: return 7'h78;
    endcase
  endfunction

  task automatic step(input logic l, input logic r, input logic rs, input string tag);
    exp_t e;
    @(negedge clk);
    win_l = l; win_r = r; rst = rs;
    if (rs) begin
      ml = 0; mr = 0; mwon = 1'b0;
    end else begin
      mwon = l | r;
      if (l) begin
        if (ml < 7) ml++;
      end else if (r) begin
        if (mr < 7) mr++;
      end
    end
    e.el = digit(ml); e.er = digit(mr); e.rs = mwon | rs; e.tag = tag;
    q.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (seg_l !== e.el || seg_r !== e.er || restart !== e.rs) begin
        n_bad++;
        $display("FAIL %s: seg_l=%h seg_r=%h restart=%b expected seg_l=%h seg_r=%h restart=%b",
                 e.tag, seg_l, seg_r, restart, e.el, e.er, e.rs);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(0, 0, 1, "R1 reset");
    step(1, 0, 1, "R8 left win in reset");
    step(0, 1, 1, "R8 right win in reset");
    step(1, 1, 1, "R2 R8 both in reset");
    step(0, 0, 0, "R7 idle no restart");
    step(1, 0, 0, "R3 R7 left win");
    step(0, 0, 0, "R7 single pulse");
    step(0, 1, 0, "R4 right win");
    step(0, 1, 0, "R4 right again");
    step(0, 0, 0, "R7 scores kept");
    step(1, 1, 0, "R5 both win");
    for (int i = 0; i < 8; i++) step(1, 0, 0, "R6 R9 left run");
    step(0, 0, 0, "R6 left held at 7");
    for (int i = 0; i < 7; i++) begin
      step(0, 1, 0, "R4 R9 right run");
      if (i % 3 == 0) step(1, 1, 0, "R5 R6 both while left full");
    end
    step(0, 1, 0, "R6 right saturate");
    step(0, 0, 0, "R6 both at 7");
    step(1, 0, 1, "R1 R2 mid reset");
    step(0, 1, 1, "R8 win during reset");
    step(0, 0, 0, "R1 cleared");
    step(0, 1, 0, "R4 after reset");
    step(0, 0, 0, "R7 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule